// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block collects five interrupt sources for a small processor core and turns them into one request line plus a handler address. Two sources are active-low external pins, two are timer overflow flags, and the fifth is a combined serial transmit/receive flag. Software sets up an enable register, a priority register and a trigger-type bit for each external pin. The block then tells the core whether a handler should run and where that handler starts.

Each external pin passes through a synchroniser. In edge mode, a high-to-low transition sets a sticky flag. In level mode, the synchronised pin drives the request directly. Enabled sources are split into a high group and a low group. Within a group, a fixed order picks the winner. A two-bit in-service state records which levels have a handler running, so a high request can interrupt a low handler. A request never interrupts a handler at its own level.

When the core accepts the request with `irq_ack`, the block does three things. It marks the winning level as in service. It clears the edge flag of an external winner. It pulses a clear strobe toward a timer winner. A pulse on `irq_reti` ends the most important running handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When bit 7 of `en_reg` is 0, `irq_req` stays 0 whatever the other enable bits and sources are.
- R2: Source enables sit in `en_reg`: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A source whose bit is 0 never wins.
- R3: Among pending sources at the same level, the winner is chosen in the order external 0, timer 0, external 1, timer 1, serial (first wins).
- R4: While `irq_req` is 1, `irq_vec` is 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial. While `irq_req` is 0, `irq_vec` reads 0.
- R5: `pri_reg` uses the same bit positions as `en_reg`, with 1 meaning high level. An enabled high-level source wins over any low-level source.
- R6: While a high-level handler is in service, `irq_req` is 0. While only a low-level handler is in service, only high-level sources can raise `irq_req`.
- R7: `irq_ack` while `irq_req` is 1 marks the winner's level as in service. An `irq_reti` pulse clears the high level if it is active, and otherwise clears the low level.
- R8: When `ext_type[i]` is 1, a falling edge on `ext_n[i]` sets a flag. The flag keeps the request pending after the pin returns high. The flag clears when that source is acknowledged.
- R9: When `ext_type[i]` is 0, the request follows the synchronised inverse of `ext_n[i]` and is not latched: it drops once the pin has been high for the synchroniser delay.
- R10: Acknowledging timer 0 or timer 1 drives `tmr_clr[0]` or `tmr_clr[1]` high in the acknowledge cycle. Acknowledging serial drives no clear, so a held serial flag requests again after return.
- R11: After reset, `irq_req` is 0, no level is in service and both edge flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | Raw external interrupt pins, active low |
| ext_type | input | 2 | Per-pin trigger select: 1 falling edge, 0 low level |
| tmr_ovf | input | 2 | Timer overflow flags (bit 0 timer 0, bit 1 timer 1) |
| ser_flag | input | 1 | Combined serial transmit/receive flag |
| en_reg | input | 8 | Enable register: bit 7 global, bits 4..0 per source |
| pri_reg | input | 8 | Priority register: bits 4..0 per source, 1 = high |
| irq_ack | input | 1 | Core accepts the current request |
| irq_reti | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Handler start address |
| tmr_clr | output | 2 | Timer overflow flag clear strobes |

## Verification
The assertions assume the following about the core's behaviour:
- `irq_ack` is raised only while `irq_req` is 1.
- `irq_ack` and `irq_reti` never fall in the same cycle.
- `irq_reti` comes only while some level is in service.
- Timer and serial flags stay high until the flag owner clears them.

The stimulus respects all of these. Every acknowledge is a single-cycle pulse, given only after the request has been checked. Every return is a single pulse matched to an earlier acknowledge. The bench drops a timer flag only after it has seen the clear strobe, and drops the serial flag itself. External pins are changed at least four cycles apart, so the synchroniser and edge detector settle between steps.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned N_SRC   = 5;
   localparam int unsigned N_EXT   = 2;
   localparam int unsigned IDX_W   = 3;

   typedef enum logic [IDX_W-1:0] {
      SRC_EXT0 = 3'd0,
      SRC_TMR0 = 3'd1,
      SRC_EXT1 = 3'd2,
      SRC_TMR1 = 3'd3,
      SRC_SER  = 3'd4
   } irq_src_e;

   typedef enum logic [0:0] {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } irq_lvl_e;

   typedef struct packed {
      logic              valid;
      logic [IDX_W-1:0]  idx;
   } irq_pick_t;
endpackage

// File: rtl/irq_ext_trig.sv
module irq_ext_trig #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic pend
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_ext_trig: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sh;
   logic                   pin_s;
   logic                   pin_prev;
   logic                   fall;
   logic                   flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '1;
         pin_prev <= 1'b1;
      end else begin
         sh       <= {sh[SYNC_STAGES-2:0], pin_n};
         pin_prev <= pin_s;
      end
   end

   assign pin_s = sh[SYNC_STAGES-1];
   assign fall  = pin_prev & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag <= 1'b0;
      else if (!edge_mode) flag <= 1'b0;
      else if (fall)       flag <= 1'b1;
      else if (clr)        flag <= 1'b0;
   end

   assign pend = edge_mode ? flag : ~pin_s;

   a_r8_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && fall) |=> flag);
   a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && flag && !clr) |=> flag);
   a_r8_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fall) |=> !flag);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int unsigned N = N_SRC
) (
   input  logic [N-1:0] req,
   output irq_pick_t    pick
);
   if (N < 1 || N > (1 << IDX_W)) begin : g_bad_n
      $error("irq_arbiter: N out of range for index width");
   end

   always_comb begin
      pick = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            pick.valid = 1'b1;
            pick.idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
   import irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      take,
   input  irq_lvl_e  take_lvl,
   input  logic      reti,
   output logic [1:0] ins
);
   logic [1:0] ins_nxt;

   always_comb begin
      ins_nxt = ins;
      if (reti) begin
         if (ins[LVL_HI]) ins_nxt[LVL_HI] = 1'b0;
         else             ins_nxt[LVL_LO] = 1'b0;
      end
      if (take) ins_nxt[take_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ins <= 2'b00;
      else        ins <= ins_nxt;
   end

   a_r7_reti_top: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !take && ins[1]) |=> (!ins[1] && ins[0] == $past(ins[0])));
   a_r7_reti_low: assert property (@(posedge clk) disable iff (!rst_n)
      (reti && !take && ins == 2'b01) |=> (ins == 2'b00));
   a_r7_take_marks: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !reti) |=> ins[$past(take_lvl)]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned VEC_W       = 16,
   parameter int unsigned VEC_BASE    = 3,
   parameter int unsigned VEC_STEP    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       ext_n,
   input  logic [1:0]       ext_type,
   input  logic [1:0]       tmr_ovf,
   input  logic             ser_flag,
   input  logic [REG_W-1:0] en_reg,
   input  logic [REG_W-1:0] pri_reg,
   input  logic             irq_ack,
   input  logic             irq_reti,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec,
   output logic [1:0]       tmr_clr
);
   localparam int unsigned GLB_BIT = REG_W - 1;
   localparam int unsigned VEC_TOP = VEC_BASE + VEC_STEP * (N_SRC - 1);

   if (REG_W < N_SRC + 1) begin : g_bad_regw
      $error("prio_irq_ctrl: REG_W too small for enables plus global bit");
   end
   if (VEC_TOP >= (1 << VEC_W)) begin : g_bad_vec
      $error("prio_irq_ctrl: vector table does not fit VEC_W");
   end

   logic [N_EXT-1:0] ext_pend;
   logic [N_EXT-1:0] ext_clr;
   logic [N_SRC-1:0] src_req;
   logic [N_SRC-1:0] live;
   logic [N_SRC-1:0] grp [2];
   irq_pick_t        pick [2];
   logic [1:0]       ins;
   logic             sel_hi;
   logic             sel_lo;
   logic [IDX_W-1:0] sel_idx;
   irq_lvl_e         sel_lvl;
   logic             take;
   logic             unused_bits;

   assign unused_bits = ^{en_reg[GLB_BIT-1:N_SRC], pri_reg[REG_W-1:N_SRC]};

   for (genvar e = 0; e < N_EXT; e++) begin : g_ext
      irq_ext_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
         .clk       (clk),
         .rst_n     (rst_n),
         .pin_n     (ext_n[e]),
         .edge_mode (ext_type[e]),
         .clr       (ext_clr[e]),
         .pend      (ext_pend[e])
      );
   end

   assign src_req[SRC_EXT0] = ext_pend[0];
   assign src_req[SRC_TMR0] = tmr_ovf[0];
   assign src_req[SRC_EXT1] = ext_pend[1];
   assign src_req[SRC_TMR1] = tmr_ovf[1];
   assign src_req[SRC_SER]  = ser_flag;

   assign live      = src_req & en_reg[N_SRC-1:0] & {N_SRC{en_reg[GLB_BIT]}};
   assign grp[LVL_HI] = live & pri_reg[N_SRC-1:0];
   assign grp[LVL_LO] = live & ~pri_reg[N_SRC-1:0];

   for (genvar l = 0; l < 2; l++) begin : g_lvl
      irq_arbiter #(.N(N_SRC)) u_arb (
         .req  (grp[l]),
         .pick (pick[l])
      );
   end

   assign sel_hi  = pick[LVL_HI].valid & ~ins[LVL_HI];
   assign sel_lo  = ~sel_hi & pick[LVL_LO].valid & (ins == 2'b00);
   assign sel_lvl = sel_hi ? LVL_HI : LVL_LO;
   assign sel_idx = sel_hi ? pick[LVL_HI].idx : pick[LVL_LO].idx;
   assign irq_req = sel_hi | sel_lo;
   assign irq_vec = irq_req ? VEC_W'(VEC_BASE + VEC_STEP * sel_idx) : '0;
   assign take    = irq_req & irq_ack;

   assign ext_clr[0] = take & (sel_idx == SRC_EXT0);
   assign ext_clr[1] = take & (sel_idx == SRC_EXT1);
   assign tmr_clr[0] = take & (sel_idx == SRC_TMR0);
   assign tmr_clr[1] = take & (sel_idx == SRC_TMR1);

   irq_inservice u_ins (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .take_lvl (sel_lvl),
      .reti     (irq_reti),
      .ins      (ins)
   );

   a_r1_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_reg[GLB_BIT] |-> !irq_req);
   a_r6_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ins[LVL_HI] |-> !irq_req);
   a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) && irq_vec <= VEC_W'(VEC_TOP)
                   && ((irq_vec - VEC_W'(VEC_BASE)) % VEC_STEP) == 0));
   a_r10_clr_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_clr != 2'b00) |-> (irq_ack && irq_req && $onehot0(tmr_clr)));
   a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ins == 2'b00));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  ext_n, ext_type, tmr_ovf;
   logic        ser_flag;
   logic [7:0]  en_reg, pri_reg;
   logic        irq_ack, irq_reti;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic [1:0]  tmr_clr;

   always #5 clk = ~clk;

   prio_irq_ctrl u_prio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_type(ext_type),
      .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .en_reg(en_reg),
      .pri_reg(pri_reg), .irq_ack(irq_ack), .irq_reti(irq_reti),
      .irq_req(irq_req), .irq_vec(irq_vec), .tmr_clr(tmr_clr)
   );

   typedef struct {
      logic        req;
      logic [15:0] vec;
      logic [1:0]  tclr;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   event ev_sample;
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   // monitor: pops the expectation and compares with the live outputs
   initial begin
      forever begin
         @(ev_sample);
         while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_tests++;
            if (irq_req !== it.req || irq_vec !== it.vec || tmr_clr !== it.tclr) begin
               n_fail++;
               $display("FAIL %s: got req=%0b vec=%h clr=%b, expected req=%0b vec=%h clr=%b",
                        it.tag, irq_req, irq_vec, tmr_clr, it.req, it.vec, it.tclr);
            end
         end
      end
   end

   task automatic expect_out(input logic r, input logic [15:0] v,
                             input logic [1:0] t, input string tag);
      exp_t it;
      it.req = r; it.vec = v; it.tclr = t; it.tag = tag;
      exp_q.push_back(it);
      ->ev_sample;
      #1;
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // acknowledge pulse, checking outputs during the acknowledge cycle
   task automatic ack_check(input logic [15:0] v, input logic [1:0] t, input string tag);
      @(negedge clk);
      irq_ack = 1'b1;
      #1;
      expect_out(1'b1, v, t, tag);
      @(posedge clk);
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic reti_pulse();
      @(negedge clk);
      irq_reti = 1'b1;
      @(posedge clk);
      @(negedge clk);
      irq_reti = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; ext_n = 2'b11; ext_type = 2'b00; tmr_ovf = 2'b00;
      ser_flag = 1'b0; en_reg = 8'h00; pri_reg = 8'h00;
      irq_ack = 1'b0; irq_reti = 1'b0;
      settle(3);
      rst_n = 1'b1;
      settle(3);
      expect_out(1'b0, 16'h0000, 2'b00, "R11 reset idle");

      ext_n[0] = 1'b0; en_reg = 8'h1F;
      settle(4);
      expect_out(1'b0, 16'h0000, 2'b00, "R1 global enable off");

      en_reg = 8'h9F;
      settle(1);
      expect_out(1'b1, 16'h0003, 2'b00, "R4 R9 level ext0 vector");

      tmr_ovf[0] = 1'b1; ser_flag = 1'b1;
      settle(1);
      expect_out(1'b1, 16'h0003, 2'b00, "R3 ext0 beats timer0 and serial");

      en_reg = 8'h9E;
      settle(1);
      expect_out(1'b1, 16'h000B, 2'b00, "R2 ext0 disabled, timer0 next");

      pri_reg = 8'h10;
      settle(1);
      expect_out(1'b1, 16'h0023, 2'b00, "R5 high serial beats low");

      ack_check(16'h0023, 2'b00, "R10 serial ack gives no clear");
      expect_out(1'b0, 16'h0000, 2'b00, "R6 high in service blocks");

      reti_pulse();
      expect_out(1'b1, 16'h0023, 2'b00, "R10 serial flag still requests");

      ser_flag = 1'b0;
      settle(1);
      expect_out(1'b1, 16'h000B, 2'b00, "R3 timer0 low winner");

      ack_check(16'h000B, 2'b01, "R10 timer0 clear strobe");
      tmr_ovf[0] = 1'b0;
      en_reg = 8'h9F;
      settle(1);
      expect_out(1'b0, 16'h0000, 2'b00, "R6 low blocked by low");

      ext_type[1] = 1'b1; pri_reg = 8'h04;
      settle(1);
      ext_n[1] = 1'b0;
      settle(4);
      ext_n[1] = 1'b1;
      settle(4);
      expect_out(1'b1, 16'h0013, 2'b00, "R8 R6 latched edge preempts low");

      ack_check(16'h0013, 2'b00, "R8 ext1 ack");
      expect_out(1'b0, 16'h0000, 2'b00, "R6 both levels in service");

      reti_pulse();
      pri_reg = 8'h05;
      settle(1);
      expect_out(1'b1, 16'h0003, 2'b00, "R7 reti cleared high level only");

      pri_reg = 8'h04;
      settle(1);
      expect_out(1'b0, 16'h0000, 2'b00, "R8 edge flag cleared on ack");

      reti_pulse();
      expect_out(1'b1, 16'h0003, 2'b00, "R7 second reti clears low");

      ext_n[0] = 1'b1;
      settle(4);
      expect_out(1'b0, 16'h0000, 2'b00, "R9 level request not latched");

      tmr_ovf[1] = 1'b1;
      settle(1);
      expect_out(1'b1, 16'h001B, 2'b00, "R4 timer1 vector");
      ack_check(16'h001B, 2'b10, "R10 timer1 clear strobe");
      tmr_ovf[1] = 1'b0;
      reti_pulse();
      expect_out(1'b0, 16'h0000, 2'b00, "R7 idle after timer1 return");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule